// File: doc/BRIEF.md
# Programmable Sample-Rate Tick Generator with Gradual Phase Correction

This block produces a sample-rate strobe from a 24.576 MHz master clock. Software enters the desired rate directly in hertz. A phase accumulator adds that value on every master clock and wraps modulo the master frequency. Each wrap emits a one-clock `sample_tick`. Because the modulus equals the master frequency, the rate value maps to output hertz with no scaling.

A second register holds a pending phase correction: an 8-bit count of 0.12-degree units plus a direction flag. The correction is not applied at once. One unit is consumed every 8 master clocks (3.072 MHz). Each consumed unit moves the accumulator forward or back by 1/3000 of a full period. Reading the register shows the units still outstanding. A new write replaces whatever remains.

Both registers return to their defaults and ignore writes while reset or power-down is held low. The phase register is also cleared, and ignores writes, while the generator is disabled.

Top module: `sample_clk_synth`

## Requirements
- R1: The accumulator adds the rate value on every master clock while the generator runs, and wraps modulo 24,576,000. `sample_tick` is high for exactly one clock in the cycle after each wrap. At 48000 Hz with no correction pending, ticks are exactly 512 clocks apart.
- R2: While `rst_n` or `pwrdn_n` is low, `rate_rd` reads 48000 (0xBB80), `phase_rd` reads 0, `dir_rd` reads 0 and no tick is produced. Writes to either register in that time are ignored.
- R3: A rate write takes effect on `rate_rd` one clock later. A value below 4000 reads back as 4000, a value above 54000 reads back as 54000, and any other value is kept exactly. Without a write, the rate does not change.
- R4: A phase write loads `wr_data[7:0]` into `phase_rd` and `wr_dir` into `dir_rd` one clock later. Direction 0 means advance and 1 means retard.
- R5: After a phase write, the pending count drops by one every 8 clocks, the first drop coming 8 clocks after the load. It stops at 0 and never rises without a write.
- R6: A phase write while units are still pending replaces the count and direction, and restarts the 8-clock step spacing from the write.
- R7: Each consumed advance unit adds 8192 to the accumulator in the same clock as the rate. If this causes a wrap, a tick results.
- R8: Each consumed retard unit subtracts 8192 in the same clock. If the sum falls below zero, the modulus is added back and no tick is produced.
- R9: While `gen_en` is low, the phase register is cleared to 0 and ignores writes. The accumulator is also held at zero, and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz master clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pwrdn_n | input | 1 | Active-low power-down, same effect as reset |
| gen_en | input | 1 | Generator enable |
| rate_wr | input | 1 | Write strobe for the rate register |
| phase_wr | input | 1 | Write strobe for the phase register |
| wr_data | input | 16 | Write data: rate in Hz, or phase count in bits 7:0 |
| wr_dir | input | 1 | Phase direction written with `phase_wr` (0 advance, 1 retard) |
| rate_rd | output | 16 | Current rate register |
| phase_rd | output | 8 | Phase units still pending |
| dir_rd | output | 1 | Current phase direction |
| sample_tick | output | 1 | One-clock sample strobe |

## Verification
The bench builds the block with its default parameters: a 24,576,000 modulus, a 16-bit rate, an 8-bit phase count, a step every 8 clocks and an 8192-unit correction. At 48 kHz the wrap interval is then an exact 512 clocks, so the tick spacing can be checked to the clock. Even the 4 kHz floor completes several periods within the run. A behavioural integer model predicts the rate, pending count, direction and tick on every clock. It follows the accumulator through advance and retard runs, mid-flight overwrites and clamped writes. This exposes any error in how a correction unit combines with the wrap.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic {
        SHIFT_ADV = 1'b0,
        SHIFT_RET = 1'b1
    } shift_dir_e;

    localparam int unsigned MCLK_HZ_DEF  = 24576000;
    localparam int unsigned RATE_MIN_DEF = 4000;
    localparam int unsigned RATE_MAX_DEF = 54000;
    localparam int unsigned RATE_RST_DEF = 48000;
    localparam int unsigned PH_UNIT_DEF  = 8192;
    localparam int unsigned STEP_DIV_DEF = 8;

endpackage

// File: rtl/sclk_rate_reg.sv
module sclk_rate_reg #(
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned RATE_MIN = 4000,
    parameter int unsigned RATE_MAX = 54000,
    parameter int unsigned RATE_RST = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr,
    input  logic [RATE_W-1:0] wdata,
    output logic [RATE_W-1:0] rate
);
    localparam logic [RATE_W-1:0] LO  = RATE_W'(RATE_MIN);
    localparam logic [RATE_W-1:0] HI  = RATE_W'(RATE_MAX);
    localparam logic [RATE_W-1:0] DEF = RATE_W'(RATE_RST);

    typedef struct packed {
        logic [RATE_W-1:0] rate;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.rate = DEF;
        end else if (wr) begin
            if (wdata < LO)      st_d.rate = LO;
            else if (wdata > HI) st_d.rate = HI;
            else                 st_d.rate = wdata;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rate = st_q.rate;

    AST_RATE_DEFAULT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> rate == DEF); // R2
    AST_RATE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !wr) |=> $stable(rate)); // R3
    AST_RATE_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr && wdata > HI) |=> rate == HI); // R3
    AST_RATE_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && wr && wdata < LO) |=> rate == LO); // R3

endmodule

// File: rtl/sclk_phase_engine.sv
module sclk_phase_engine
    import sclk_pkg::*;
#(
    parameter int unsigned PH_W     = 8,
    parameter int unsigned STEP_DIV = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            gen_en,
    input  logic            wr,
    input  logic [PH_W-1:0] wmag,
    input  logic            wdir,
    output logic [PH_W-1:0] mag,
    output shift_dir_e      dir,
    output logic            step_adv,
    output logic            step_ret
);
    localparam int unsigned    DIV_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(STEP_DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0]  mag;
        shift_dir_e       dir;
        logic [DIV_W-1:0] div;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   run;
    logic   step;

    assign run  = !hold && gen_en;
    assign step = run && !wr && (st_q.div == LAST) && (st_q.mag != '0);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.mag = '0;
            st_d.dir = SHIFT_ADV;
            st_d.div = '0;
        end else if (wr) begin
            st_d.mag = wmag;
            st_d.dir = shift_dir_e'(wdir);
            st_d.div = '0;
        end else begin
            st_d.div = (st_q.div == LAST) ? '0 : st_q.div + 1'b1;
            if (step) st_d.mag = st_q.mag - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mag      = st_q.mag;
    assign dir      = st_q.dir;
    assign step_adv = step && (st_q.dir == SHIFT_ADV);
    assign step_ret = step && (st_q.dir == SHIFT_RET);

    AST_PH_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> mag == '0); // R9
    AST_PH_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr) |=> mag <= $past(mag)); // R5
    AST_PH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr) |=> (mag == $past(wmag)) && (dir == shift_dir_e'($past(wdir)))); // R4
    AST_PH_CLEAR_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (mag == '0) && (dir == SHIFT_ADV)); // R2
    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_adv, step_ret})); // R7

endmodule

// File: rtl/sclk_accum.sv
module sclk_accum #(
    parameter int unsigned MCLK_HZ = 24576000,
    parameter int unsigned RATE_W  = 16,
    parameter int unsigned PH_UNIT = 8192
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    input  logic              step_adv,
    input  logic              step_ret,
    output logic              tick
);
    localparam int unsigned ACC_W = $clog2(MCLK_HZ) + 2;
    localparam logic signed [ACC_W-1:0] MODV = ACC_W'(MCLK_HZ);
    localparam logic signed [ACC_W-1:0] UNIT = ACC_W'(PH_UNIT);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic                    tick;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] adj;

    always_comb begin
        adj = '0;
        if (step_adv)      adj = UNIT;
        else if (step_ret) adj = -UNIT;
        sum = st_q.acc + $signed(ACC_W'(rate)) + adj;
    end

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.acc  = '0;
            st_d.tick = 1'b0;
        end else if (sum >= MODV) begin
            st_d.acc  = sum - MODV;
            st_d.tick = 1'b1;
        end else if (sum < 0) begin
            st_d.acc  = sum + MODV;
            st_d.tick = 1'b0;
        end else begin
            st_d.acc  = sum;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign tick = st_q.tick;

    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc >= 0) && (st_q.acc < MODV)); // R1
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R1
    AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick); // R9
    AST_RET_NEVER_TICKS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step_ret && (st_q.acc + $signed(ACC_W'(rate)) < UNIT)) |=> !tick); // R8

endmodule

// File: rtl/sample_clk_synth.sv
module sample_clk_synth
    import sclk_pkg::*;
#(
    parameter int unsigned MCLK_HZ  = MCLK_HZ_DEF,
    parameter int unsigned RATE_W   = 16,
    parameter int unsigned RATE_MIN = RATE_MIN_DEF,
    parameter int unsigned RATE_MAX = RATE_MAX_DEF,
    parameter int unsigned RATE_RST = RATE_RST_DEF,
    parameter int unsigned PH_W     = 8,
    parameter int unsigned STEP_DIV = STEP_DIV_DEF,
    parameter int unsigned PH_UNIT  = PH_UNIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              gen_en,
    input  logic              rate_wr,
    input  logic              phase_wr,
    input  logic [RATE_W-1:0] wr_data,
    input  logic              wr_dir,
    output logic [RATE_W-1:0] rate_rd,
    output logic [PH_W-1:0]   phase_rd,
    output logic              dir_rd,
    output logic              sample_tick
);
    logic       hold_w;
    logic       run_w;
    logic       step_adv_w;
    logic       step_ret_w;
    shift_dir_e dir_w;

    assign hold_w = !rst_n || !pwrdn_n;
    assign run_w  = !hold_w && gen_en;

    sclk_rate_reg #(
        .RATE_W  (RATE_W),
        .RATE_MIN(RATE_MIN),
        .RATE_MAX(RATE_MAX),
        .RATE_RST(RATE_RST)
    ) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold_w),
        .wr   (rate_wr),
        .wdata(wr_data),
        .rate (rate_rd)
    );

    sclk_phase_engine #(
        .PH_W    (PH_W),
        .STEP_DIV(STEP_DIV)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold_w),
        .gen_en  (gen_en),
        .wr      (phase_wr),
        .wmag    (wr_data[PH_W-1:0]),
        .wdir    (wr_dir),
        .mag     (phase_rd),
        .dir     (dir_w),
        .step_adv(step_adv_w),
        .step_ret(step_ret_w)
    );

    assign dir_rd = (dir_w == SHIFT_RET);

    sclk_accum #(
        .MCLK_HZ(MCLK_HZ),
        .RATE_W (RATE_W),
        .PH_UNIT(PH_UNIT)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .rate    (rate_rd),
        .step_adv(step_adv_w),
        .step_ret(step_ret_w),
        .tick    (sample_tick)
    );

    AST_NO_TICK_IN_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> !sample_tick); // R2

endmodule

// File: tb/sim_sample_clk_synth.sv
module sim_sample_clk_synth;

    localparam int MOD  = 24576000;
    localparam int UNIT = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic        gen_en = 1'b1;
    logic        rate_wr = 1'b0;
    logic        phase_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_dir = 1'b0;
    logic [15:0] rate_rd;
    logic [7:0]  phase_rd;
    logic        dir_rd;
    logic        sample_tick;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 0;

    // behavioural reference state
    int m_rate = 48000;
    int m_mag  = 0;
    int m_dir  = 0;
    int m_div  = 0;
    int m_acc  = 0;
    int m_tick = 0;

    always #10 clk = ~clk;

    sample_clk_synth u0 (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .gen_en(gen_en),
        .rate_wr(rate_wr), .phase_wr(phase_wr), .wr_data(wr_data), .wr_dir(wr_dir),
        .rate_rd(rate_rd), .phase_rd(phase_rd), .dir_rd(dir_rd), .sample_tick(sample_tick)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit hold, run, step;
        int s, n_rate, n_mag, n_dir, n_div, n_acc, n_tick;
        cycles++;
        hold = !rst_n || !pwrdn_n;
        run  = !hold && gen_en;
        step = run && !phase_wr && (m_div == 7) && (m_mag != 0);
        n_rate = m_rate;
        if (hold) n_rate = 48000;
        else if (rate_wr) n_rate = (wr_data < 4000) ? 4000 : (wr_data > 54000) ? 54000 : int'(wr_data);
        n_mag = m_mag; n_dir = m_dir; n_div = m_div;
        if (!run) begin
            n_mag = 0; n_dir = 0; n_div = 0;
        end else if (phase_wr) begin
            n_mag = int'(wr_data[7:0]); n_dir = int'(wr_dir); n_div = 0;
        end else begin
            n_div = (m_div + 1) % 8;
            if (step) n_mag = m_mag - 1;
        end
        if (!run) begin
            n_acc = 0; n_tick = 0;
        end else begin
            s = m_acc + m_rate + (step ? (m_dir != 0 ? -UNIT : UNIT) : 0);
            n_tick = 0;
            if (s >= MOD) begin s -= MOD; n_tick = 1; end
            else if (s < 0) s += MOD;
            n_acc = s;
        end
        m_rate = n_rate; m_mag = n_mag; m_dir = n_dir; m_div = n_div;
        m_acc = n_acc; m_tick = n_tick;
    end

    always @(negedge clk) begin
        if (model_on) begin
            check(rate_rd == 16'(m_rate), "R2 R3 rate", int'(rate_rd), m_rate);
            check(phase_rd == 8'(m_mag), "R5 R6 pending", int'(phase_rd), m_mag);
            check(dir_rd == 1'(m_dir), "R4 dir", int'(dir_rd), m_dir);
            check(sample_tick == 1'(m_tick), "R1 R7 R8 tick", int'(sample_tick), m_tick);
        end
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_rate(input int v);
        rate_wr = 1'b1; wr_data = 16'(v);
        @(negedge clk);
        rate_wr = 1'b0;
    endtask

    task automatic wr_phase(input int v, input bit d);
        phase_wr = 1'b1; wr_data = 16'(v); wr_dir = d;
        @(negedge clk);
        phase_wr = 1'b0;
    endtask

    initial begin
        int gap;
        idle(3);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        // R2: reset state
        check(rate_rd == 16'hBB80, "R2 reset rate", int'(rate_rd), 48000);
        check(phase_rd == 0, "R2 reset phase", int'(phase_rd), 0);
        check(sample_tick == 0, "R2 reset tick", int'(sample_tick), 0);

        // R1: tick spacing at 48 kHz
        while (sample_tick !== 1'b1) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (sample_tick !== 1'b1);
        check(gap == 512, "R1 tick spacing", gap, 512);

        // R3: clamping and exact values
        wr_rate(100);
        check(rate_rd == 4000, "R3 clamp low", int'(rate_rd), 4000);
        wr_rate(16'hFFFF);
        check(rate_rd == 54000, "R3 clamp high", int'(rate_rd), 54000);
        wr_rate(16'h1F40);
        check(rate_rd == 8000, "R3 exact", int'(rate_rd), 8000);
        wr_rate(54000);
        check(rate_rd == 54000, "R3 upper bound kept", int'(rate_rd), 54000);
        wr_rate(4000);
        check(rate_rd == 4000, "R3 lower bound kept", int'(rate_rd), 4000);
        idle(7000);

        // R4, R5: load and countdown
        wr_rate(48000);
        wr_phase(3, 1'b0);
        check(phase_rd == 3 && dir_rd == 0, "R4 load advance", int'(phase_rd), 3);
        idle(7);
        check(phase_rd == 3, "R5 before first step", int'(phase_rd), 3);
        idle(1);
        check(phase_rd == 2, "R5 first step", int'(phase_rd), 2);
        idle(16);
        check(phase_rd == 0, "R5 drained", int'(phase_rd), 0);
        idle(40);
        check(phase_rd == 0, "R5 stays at zero", int'(phase_rd), 0);

        // R6: overwrite mid-flight
        wr_phase(20, 1'b0);
        idle(12);
        wr_phase(10, 1'b1);
        check(phase_rd == 10 && dir_rd == 1, "R6 overwrite", int'(phase_rd), 10);
        idle(7);
        check(phase_rd == 10, "R6 spacing restart", int'(phase_rd), 10);
        idle(1);
        check(phase_rd == 9, "R6 step after restart", int'(phase_rd), 9);

        // R7: long advance run; R8: long retard run at low rate
        wr_phase(255, 1'b0);
        idle(2100);
        wr_rate(4000);
        wr_phase(255, 1'b1);
        idle(2100);
        wr_phase(255, 1'b1);
        idle(6200);
        check(phase_rd == 0, "R8 retard drained", int'(phase_rd), 0);

        // R2: power-down forces defaults and blocks writes
        wr_phase(50, 1'b1);
        pwrdn_n = 1'b0;
        @(negedge clk);
        wr_rate(9000);
        wr_phase(5, 1'b1);
        check(rate_rd == 48000, "R2 rate write ignored", int'(rate_rd), 48000);
        check(phase_rd == 0 && dir_rd == 0, "R2 phase write ignored", int'(phase_rd), 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sample_tick) check(1'b0, "R2 tick in power-down", 1, 0);
        end
        pwrdn_n = 1'b1;
        idle(600);

        // R9: generator disable
        wr_phase(40, 1'b0);
        gen_en = 1'b0;
        @(negedge clk);
        check(phase_rd == 0, "R9 cleared", int'(phase_rd), 0);
        wr_phase(7, 1'b1);
        check(phase_rd == 0 && dir_rd == 0, "R9 write ignored", int'(phase_rd), 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sample_tick) check(1'b0, "R9 tick while disabled", 1, 0);
        end
        gen_en = 1'b1;
        idle(1100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule